// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register and an external trigger input. A single count register serves four operating modes. Capture mode latches the running count on a falling trigger edge. Reload mode restarts from the stored value on overflow or on a trigger edge. Up/down mode lets the trigger pin choose the count direction. Baud mode generates serial bit-clock ticks. A clock-out option drives a square wave whose period follows from the reload value. All timing is referenced to a clock-enable `tick` input, so one `tick` stands for one oscillator period.

Software sets the mode through one 8-bit control write. It loads the count and the capture/reload value through their own write strobes, and it clears or sets the two flags with a flag write. The block raises `irq` when the overflow flag is set. It also raises `irq` when the external flag is set in any mode except up/down. Receive and transmit ticks are divided by 16 from either this timer's wraps or a companion timer's overflow strobe.

Control byte bit positions: bit0 run, bit1 external count source, bit2 capture select, bit3 trigger enable, bit4 receive-baud select, bit5 transmit-baud select, bit6 up/down enable, bit7 clock-out enable. Flag byte: bit0 overflow flag, bit1 external flag.

Top module: `cr_timer16`

## Requirements
- R1: After reset the count, capture register, both flags, `irq`, `rxTick`, `txTick` and `clkOut` are all 0.
- R2: With run set and the internal source selected, the count advances once every 12 ticks. The first advance lands 12 ticks after the clock edge that latches run. With run clear the count holds.
- R3: The mode is chosen by priority: baud (bit4 or bit5), then capture (bit2), then up/down (bit6), and otherwise reload. In reload mode, an increment from 0xFFFF loads the capture/reload value and sets the overflow flag.
- R4: A falling trigger edge is a high sample followed by a low sample on successive ticks, and it acts only when trigger enable is set. In reload mode the edge loads the count from the capture/reload value and sets the external flag. A rising edge has no effect.
- R5: In capture mode, a falling trigger edge copies the count into the capture register and sets the external flag, and leaves the count unchanged. With trigger enable clear, the capture register is untouched. The count wraps from 0xFFFF to 0x0000 and sets the overflow flag.
- R6: In up/down mode, the trigger pin high counts up and low counts down. Counting down from a count equal to the capture/reload value gives 0xFFFF. Counting up from 0xFFFF loads the capture/reload value. Both cases set the overflow flag.
- R7: In up/down mode the external flag toggles on every wrap in either direction, and trigger edges neither reload nor set it.
- R8: In baud mode the count advances every 2 ticks and reloads on overflow, and the overflow flag is never set.
- R9: `rxTick` (or `txTick`) pulses for one cycle on every 16th source event. The source is this timer's wraps when bit4 (or bit5) is set, and `t1Ovf` otherwise. The pulse appears on the cycle after the clock edge that sees the 16th event.
- R10: With clock-out enabled, the count advances every 2 ticks and `clkOut` toggles on each wrap. This gives a period of 4 x (65536 - reload) ticks. `clkOut` is 0 while clock-out is disabled.
- R11: With the external count source selected (and clock-out disabled), the count advances once per falling edge of `cntPin`, sampled on ticks, and does not advance otherwise.
- R12: `irq` is the overflow flag ORed with the external flag, and the external flag is masked in up/down mode.
- R13: Count, capture/reload and flag writes take effect at the next clock edge. In the same cycle they override any hardware update of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable, one per oscillator period |
| cntPin | input | 1 | External count input |
| trigPin | input | 1 | Trigger / direction input |
| t1Ovf | input | 1 | Companion timer overflow strobe |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte |
| cntWe | input | 1 | Count write strobe |
| cntWdata | input | 16 | Count write value |
| capWe | input | 1 | Capture/reload write strobe |
| capWdata | input | 16 | Capture/reload write value |
| flagWe | input | 1 | Flag write strobe |
| flagWdata | input | 2 | Flag write value (bit0 overflow, bit1 external) |
| count | output | 16 | Current count |
| capture | output | 16 | Capture/reload register |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External flag |
| irq | output | 1 | Interrupt request |
| rxTick | output | 1 | Receive baud tick |
| txTick | output | 1 | Transmit baud tick |
| clkOut | output | 1 | Square-wave clock output |

## Verification
A prescaler phase error shows on `count` within one 12-tick period, and it also shifts every later overflow and baud tick. A wrong mode decode or direction shows at the first wrap: the count reloads, clears or goes to 0xFFFF where it should not, or `ovfFlag` rises in baud mode, all visible one cycle after the wrap. A bad edge sampler misfires on the first trigger pulse, where `capture`, `count` and `extFlag` move at the edge that sees the low sample. Divider errors surface as a misplaced `rxTick`/`txTick` pulse on the 16th source event.

// File: rtl/cr_timer16_pkg.sv
package cr_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_BAUD    = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic     step;
    logic     dirUp;
    logic     trigFall;
    tmrMode_e mode;
    logic     clkOutEn;
    logic     rxSel;
    logic     txSel;
  } tmrStrobe_t;

  localparam int CTRL_W    = 8;
  localparam int B_RUN     = 0;
  localparam int B_EXTCNT  = 1;
  localparam int B_CAPSEL  = 2;
  localparam int B_TRIGEN  = 3;
  localparam int B_RXBAUD  = 4;
  localparam int B_TXBAUD  = 5;
  localparam int B_UPDN    = 6;
  localparam int B_CLKOUT  = 7;
endpackage

// File: rtl/cr_timer16_ctrl.sv
module cr_timer16_ctrl
  import cr_timer16_pkg::*;
#(
  parameter int TIMER_DIV = 12,
  parameter int FAST_DIV  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output tmrStrobe_t        strb
);
  localparam int PRE_W = $clog2(TIMER_DIV);
  localparam logic [PRE_W-1:0] SLOW_LIM = PRE_W'(TIMER_DIV - 1);
  localparam logic [PRE_W-1:0] FAST_LIM = PRE_W'(FAST_DIV - 1);

  logic [CTRL_W-1:0] ctrlQ;
  logic [PRE_W-1:0]  preQ, preLim;
  logic              trigS, cntS;
  logic              run, fast, useExt, preHit, cntFall;
  tmrMode_e          mode;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlWdata;
  end

  assign run    = ctrlQ[B_RUN];
  assign fast   = ctrlQ[B_RXBAUD] | ctrlQ[B_TXBAUD] | ctrlQ[B_CLKOUT];
  assign useExt = ctrlQ[B_EXTCNT] & ~fast;
  assign preLim = fast ? FAST_LIM : SLOW_LIM;
  assign preHit = tick && (preQ >= preLim);

  always_comb begin
    if (ctrlQ[B_RXBAUD] | ctrlQ[B_TXBAUD]) mode = MODE_BAUD;
    else if (ctrlQ[B_CAPSEL])              mode = MODE_CAPTURE;
    else if (ctrlQ[B_UPDN])                mode = MODE_UPDOWN;
    else                                   mode = MODE_RELOAD;
  end

  // shared prescaler, held at zero while stopped
  always_ff @(posedge clk) begin
    if (!rstN || !run) preQ <= '0;
    else if (tick && !useExt) preQ <= preHit ? '0 : preQ + PRE_W'(1);
  end

  // pin samplers, updated once per tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigS <= 1'b0;
      cntS  <= 1'b0;
    end else if (tick) begin
      trigS <= trigPin;
      cntS  <= cntPin;
    end
  end

  assign cntFall = tick & cntS & ~cntPin;

  always_comb begin
    strb.step     = run & (useExt ? cntFall : preHit);
    strb.dirUp    = (mode != MODE_UPDOWN) | trigPin;
    strb.trigFall = tick & trigS & ~trigPin & ctrlQ[B_TRIGEN];
    strb.mode     = mode;
    strb.clkOutEn = ctrlQ[B_CLKOUT];
    strb.rxSel    = ctrlQ[B_RXBAUD];
    strb.txSel    = ctrlQ[B_TXBAUD];
  end

  // R2: the prescaler restarts from zero, so no step in the first running cycle
  a_r2_no_step_on_start: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(run) && !useExt) |-> !strb.step);

  // R4: an edge needs the pin to have been seen high on an earlier tick
  a_r4_fall_after_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigFall && $past(rstN)) |-> $past(trigPin || trigS));
endmodule

// File: rtl/cr_timer16_dp.sv
module cr_timer16_dp
  import cr_timer16_pkg::*;
#(
  parameter int W        = 16,
  parameter int BAUD_DIV = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strb,
  input  logic         t1Ovf,
  input  logic         cntWe,
  input  logic [W-1:0] cntWdata,
  input  logic         capWe,
  input  logic [W-1:0] capWdata,
  input  logic         flagWe,
  input  logic [1:0]   flagWdata,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         ovfFlag,
  output logic         extFlag,
  output logic         irq,
  output logic         rxTick,
  output logic         txTick,
  output logic         clkOut
);
  localparam int DIV_W = $clog2(BAUD_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BAUD_DIV - 1);

  logic [W-1:0] cntQ, capQ;
  logic         ovfQ, extQ, clkQ;
  logic         atMax, atCap, wrap, edgeAct, isUpdn;
  logic [1:0]   src, tickQ;

  assign isUpdn  = (strb.mode == MODE_UPDOWN);
  assign atMax   = (cntQ == '1);
  assign atCap   = (cntQ == capQ);
  assign wrap    = strb.step & (strb.dirUp ? atMax : atCap);
  assign edgeAct = strb.trigFall & ~isUpdn;

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (cntWe) cntQ <= cntWdata;
    else if (edgeAct && strb.mode == MODE_RELOAD) cntQ <= capQ;
    else if (strb.step) begin
      if (strb.dirUp) begin
        if (!atMax) cntQ <= cntQ + W'(1);
        else if (strb.mode == MODE_CAPTURE) cntQ <= '0;
        else cntQ <= capQ;
      end else begin
        cntQ <= atCap ? '1 : cntQ - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) capQ <= '0;
    else if (capWe) capQ <= capWdata;
    else if (edgeAct && strb.mode == MODE_CAPTURE) capQ <= cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
      extQ <= 1'b0;
    end else if (flagWe) begin
      ovfQ <= flagWdata[0];
      extQ <= flagWdata[1];
    end else begin
      ovfQ <= ovfQ | (wrap & (strb.mode != MODE_BAUD));
      extQ <= isUpdn ? (extQ ^ wrap) : (extQ | edgeAct);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.clkOutEn) clkQ <= 1'b0;
    else if (wrap) clkQ <= ~clkQ;
  end

  assign src[0] = strb.rxSel ? wrap : t1Ovf;
  assign src[1] = strb.txSel ? wrap : t1Ovf;

  for (genvar g = 0; g < 2; g++) begin : g_baud
    logic [DIV_W-1:0] divQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        divQ     <= '0;
        tickQ[g] <= 1'b0;
      end else begin
        tickQ[g] <= src[g] && (divQ == DIV_LAST);
        if (src[g]) divQ <= (divQ == DIV_LAST) ? '0 : divQ + DIV_W'(1);
      end
    end
  end

  assign count   = cntQ;
  assign capture = capQ;
  assign ovfFlag = ovfQ;
  assign extFlag = extQ;
  assign irq     = ovfQ | (extQ & ~isUpdn);
  assign rxTick  = tickQ[0];
  assign txTick  = tickQ[1];
  assign clkOut  = clkQ;

  // R3: an up-wrap in reload mode restarts from the stored value
  a_r3_reload_on_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.dirUp && atMax && strb.mode == MODE_RELOAD && !cntWe)
      |=> (cntQ == $past(capQ)));

  // R5: capture latches the pre-edge count
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    (edgeAct && strb.mode == MODE_CAPTURE && !capWe) |=> (capQ == $past(cntQ)));

  // R6: ordinary down step decrements by one
  a_r6_down_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.dirUp && !atCap && !cntWe) |=> (cntQ == $past(cntQ) - W'(1)));

  // R7: every up/down wrap flips the external flag
  a_r7_ext_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (isUpdn && wrap && !flagWe) |=> (extQ != $past(extQ)));

  // R8: baud mode never raises the overflow flag
  a_r8_no_ovf_in_baud: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode == MODE_BAUD && !flagWe && !ovfQ) |=> !ovfQ);

  // R9: baud ticks are single-cycle pulses
  a_r9_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |=> !rxTick);

  // R10: the clock output parks low when disabled
  a_r10_clkout_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clkOutEn |=> !clkOut);
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer16_pkg::*;
#(
  parameter int W         = 16,
  parameter int TIMER_DIV = 12,
  parameter int FAST_DIV  = 2,
  parameter int BAUD_DIV  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              t1Ovf,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntWe,
  input  logic [W-1:0]      cntWdata,
  input  logic              capWe,
  input  logic [W-1:0]      capWdata,
  input  logic              flagWe,
  input  logic [1:0]        flagWdata,
  output logic [W-1:0]      count,
  output logic [W-1:0]      capture,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              irq,
  output logic              rxTick,
  output logic              txTick,
  output logic              clkOut
);
  tmrStrobe_t strb;

  cr_timer16_ctrl #(.TIMER_DIV(TIMER_DIV), .FAST_DIV(FAST_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .cntPin(cntPin), .trigPin(trigPin),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .strb(strb)
  );

  cr_timer16_dp #(.W(W), .BAUD_DIV(BAUD_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .t1Ovf(t1Ovf),
    .cntWe(cntWe), .cntWdata(cntWdata), .capWe(capWe), .capWdata(capWdata),
    .flagWe(flagWe), .flagWdata(flagWdata),
    .count(count), .capture(capture), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .irq(irq), .rxTick(rxTick), .txTick(txTick), .clkOut(clkOut)
  );
endmodule

// File: tb/cr_timer16_tb_top.sv
`timescale 1ns/100ps
module cr_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        cntPin = 1'b0, trigPin = 1'b0, t1Ovf = 1'b0;
  logic        ctrlWe = 1'b0, cntWe = 1'b0, capWe = 1'b0, flagWe = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic [15:0] cntWdata = '0, capWdata = '0;
  logic [1:0]  flagWdata = '0;
  logic [15:0] count, capture;
  logic        ovfFlag, extFlag, irq, rxTick, txTick, clkOut;

  localparam int S_CNT = 0, S_CAP = 1, S_OVF = 2, S_EXT = 3, S_IRQ = 4,
                 S_RXT = 5, S_TXT = 6, S_CLK = 7;

  typedef struct { string tag; int sel; logic [15:0] exp; } sbItem_t;
  sbItem_t sbQ[$];
  sbItem_t item;
  int nChecks = 0, nFails = 0;
  logic [15:0] act;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cr_timer16 dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .cntPin(cntPin), .trigPin(trigPin),
    .t1Ovf(t1Ovf), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .cntWe(cntWe),
    .cntWdata(cntWdata), .capWe(capWe), .capWdata(capWdata), .flagWe(flagWe),
    .flagWdata(flagWdata), .count(count), .capture(capture), .ovfFlag(ovfFlag),
    .extFlag(extFlag), .irq(irq), .rxTick(rxTick), .txTick(txTick), .clkOut(clkOut)
  );

  function automatic logic [15:0] getOut(int sel);
    case (sel)
      S_CNT:   return count;
      S_CAP:   return capture;
      S_OVF:   return {15'b0, ovfFlag};
      S_EXT:   return {15'b0, extFlag};
      S_IRQ:   return {15'b0, irq};
      S_RXT:   return {15'b0, rxTick};
      S_TXT:   return {15'b0, txTick};
      default: return {15'b0, clkOut};
    endcase
  endfunction

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sbQ.size() != 0) begin
      item = sbQ.pop_front();
      nChecks++;
      act = getOut(item.sel);
      if (act !== item.exp) begin
        nFails++;
        $display("FAIL %s: got %h expected %h", item.tag, act, item.exp);
      end
    end
  end

  task automatic expect_(string tag, int sel, logic [15:0] v);
    sbItem_t it;
    it.tag = tag; it.sel = sel; it.exp = v;
    sbQ.push_back(it);
  endtask

  task automatic clocks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrCtrl(logic [7:0] v);
    ctrlWe = 1'b1; ctrlWdata = v; clocks(1); ctrlWe = 1'b0;
  endtask
  task automatic wrCnt(logic [15:0] v);
    cntWe = 1'b1; cntWdata = v; clocks(1); cntWe = 1'b0;
  endtask
  task automatic wrCap(logic [15:0] v);
    capWe = 1'b1; capWdata = v; clocks(1); capWe = 1'b0;
  endtask
  task automatic wrFlag(logic [1:0] v);
    flagWe = 1'b1; flagWdata = v; clocks(1); flagWe = 1'b0;
  endtask
  task automatic trigFall();
    trigPin = 1'b1; clocks(1); trigPin = 1'b0; clocks(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end

  initial begin
    clocks(3);
    rstN = 1'b1;
    expect_("R1 count", S_CNT, 16'h0);
    expect_("R1 capture", S_CAP, 16'h0);
    expect_("R1 ovf", S_OVF, 0);
    expect_("R1 ext", S_EXT, 0);
    expect_("R1 irq", S_IRQ, 0);
    expect_("R1 rxTick", S_RXT, 0);
    expect_("R1 clkOut", S_CLK, 0);

    // reload mode, /12 prescaler
    wrCap(16'hFFF0);
    wrCnt(16'hFFFE);
    expect_("R13 capture write", S_CAP, 16'hFFF0);
    expect_("R13 count write", S_CNT, 16'hFFFE);
    wrCtrl(8'h01);
    clocks(11); expect_("R2 no step before 12 ticks", S_CNT, 16'hFFFE);
    clocks(1);  expect_("R2 first step", S_CNT, 16'hFFFF);
    clocks(12);
    expect_("R3 reload value", S_CNT, 16'hFFF0);
    expect_("R3 ovf set", S_OVF, 1);
    expect_("R12 irq from ovf", S_IRQ, 1);
    wrCtrl(8'h00);
    wrFlag(2'b00);
    expect_("R13 flag clear", S_OVF, 0);
    expect_("R12 irq low", S_IRQ, 0);

    // trigger reload
    wrCtrl(8'h08);
    wrCnt(16'h1234);
    clocks(3); expect_("R2 hold while stopped", S_CNT, 16'h1234);
    trigFall();
    expect_("R4 edge reload", S_CNT, 16'hFFF0);
    expect_("R4 ext set", S_EXT, 1);
    expect_("R12 irq from ext", S_IRQ, 1);
    wrFlag(2'b00);
    wrCnt(16'h0055);
    trigPin = 1'b1; clocks(2);
    expect_("R4 rising edge ignored", S_CNT, 16'h0055);
    expect_("R4 rising edge no flag", S_EXT, 0);

    // capture
    wrCtrl(8'h0C);
    wrCnt(16'hABCD);
    trigPin = 1'b0; clocks(1);
    expect_("R5 captured value", S_CAP, 16'hABCD);
    expect_("R5 count kept", S_CNT, 16'hABCD);
    expect_("R5 ext set", S_EXT, 1);
    wrFlag(2'b00);
    wrCtrl(8'h04);
    wrCnt(16'hFFFF);
    trigFall();
    expect_("R5 no capture without enable", S_CAP, 16'hABCD);
    expect_("R5 no flag without enable", S_EXT, 0);
    wrCtrl(8'h05);
    clocks(12);
    expect_("R5 wrap to zero", S_CNT, 16'h0000);
    expect_("R5 ovf on wrap", S_OVF, 1);
    wrCtrl(8'h00);
    wrFlag(2'b00);

    // up/down
    trigPin = 1'b0;
    wrCap(16'h0010);
    wrCnt(16'h0011);
    wrCtrl(8'h41);
    clocks(12); expect_("R6 count down", S_CNT, 16'h0010);
    clocks(12);
    expect_("R6 underflow to max", S_CNT, 16'hFFFF);
    expect_("R7 ext toggled on", S_EXT, 1);
    expect_("R6 ovf on underflow", S_OVF, 1);
    wrFlag(2'b10);
    expect_("R7 ext kept", S_EXT, 1);
    expect_("R7 irq masked in updown", S_IRQ, 0);
    trigPin = 1'b1;
    clocks(11);
    expect_("R6 up overflow reload", S_CNT, 16'h0010);
    expect_("R7 ext toggled off", S_EXT, 0);
    expect_("R6 ovf on overflow", S_OVF, 1);
    wrCtrl(8'h48);
    wrFlag(2'b00);
    wrCnt(16'h0777);
    trigFall();
    expect_("R7 edge no reload", S_CNT, 16'h0777);
    expect_("R7 edge no flag", S_EXT, 0);

    // baud
    wrCap(16'hFFFE);
    wrCnt(16'hFFFE);
    wrCtrl(8'h11);
    clocks(4);
    expect_("R8 reload in baud", S_CNT, 16'hFFFE);
    expect_("R8 no ovf", S_OVF, 0);
    clocks(59); expect_("R9 rx before 16th", S_RXT, 0);
    clocks(1);
    expect_("R9 rx on 16th wrap", S_RXT, 1);
    expect_("R9 tx idle", S_TXT, 0);
    clocks(1);
    expect_("R9 rx single pulse", S_RXT, 0);
    expect_("R8 still no ovf", S_OVF, 0);
    wrCtrl(8'h00);
    t1Ovf = 1'b1;
    clocks(15); expect_("R9 tx before 16th", S_TXT, 0);
    clocks(1);  expect_("R9 tx from t1Ovf", S_TXT, 1);
    t1Ovf = 1'b0;
    clocks(1);  expect_("R9 tx single pulse", S_TXT, 0);

    // clock out
    wrCap(16'hFFFE);
    wrCnt(16'hFFFE);
    wrCtrl(8'h81);
    clocks(3); expect_("R10 low before wrap", S_CLK, 0);
    clocks(1); expect_("R10 high after wrap", S_CLK, 1);
    clocks(3); expect_("R10 held high", S_CLK, 1);
    clocks(1); expect_("R10 low after next wrap", S_CLK, 0);
    wrCtrl(8'h00);

    // external count
    wrCnt(16'h0000);
    wrCtrl(8'h03);
    for (int i = 0; i < 3; i++) begin
      cntPin = 1'b1; clocks(1);
      cntPin = 1'b0; clocks(1);
    end
    expect_("R11 three falls", S_CNT, 16'h0003);
    clocks(20);
    expect_("R11 no count without edge", S_CNT, 16'h0003);

    clocks(2);
    done = 1'b1;
    summary();
  end
endmodule